// File: doc/BRIEF.md
# Sampling Converter Serial Readout Model

This block is a synthesizable model of the digital face of a 12-bit sampling converter. It lets a chip-level environment stand in for a real converter. A falling edge on the active-low convert request starts a conversion. In that same cycle the word on the parallel test port is captured, and the busy flag is raised for a fixed number of system-clock cycles. When the conversion finishes, a 16-bit frame is placed on a serial data pin. The frame carries four zero bits and then the captured word, in straight binary with the most significant bit first.

The frame is paced by a serial clock that comes from outside and is not tied to the system clock. That clock passes through a synchroniser before its falling edges are used. On each falling edge the bit already on the pin is kept for a programmable hold time before the next bit replaces it, so a reader can sample on the same edge. The 16th edge releases the pin instead of advancing it. The three-state pin is expressed as a data output plus an output enable. A power-down flag is set when the convert request is still low as a conversion ends, and it is cleared by the next rising edge of that request.

Top module: `conv_serial_emu`

## Requirements
- R1: A high-to-low change of `conv_start_n` seen at a clock edge while idle captures `sample_word` at that edge. Later changes of `sample_word` do not affect that conversion's frame.
- R2: `busy_o` goes high at the clock edge that sees the falling request and stays high for exactly CONV_CYCLES clock cycles.
- R3: A further falling edge of `conv_start_n` while `busy_o` is high neither restarts the conversion nor recaptures the word.
- R4: If `conv_start_n` is low at the edge where `busy_o` falls, `sleep_o` becomes 1 at that edge. If it is high there, `sleep_o` stays 0. A rising edge of `conv_start_n` clears `sleep_o` at the next clock edge.
- R5: At the edge where `busy_o` falls, `sdata_oe_o` becomes 1 and `sdata_o` shows frame bit 0. The frame is bits 15..12 = 0 and bits 11..0 = the captured word MSB first, so a reader sampling just before each of 16 falling `sclk` edges obtains the frame in that order.
- R6: `sclk` passes through SYNC_STAGES flip-flops. A falling edge that is set up before clock edge k is acted on at edge k+SYNC_STAGES. The current bit stays on `sdata_o` until edge k+SYNC_STAGES+HOLD_CYCLES, where the next bit appears.
- R7: On the 16th accepted falling edge the last bit is held for HOLD_CYCLES cycles, then `sdata_oe_o` goes to 0 and stays 0 until the next conversion ends.
- R8: Falling `sclk` edges acted on while `busy_o` is high are ignored. This includes an edge acted on at the very edge where the conversion completes.
- R9: After reset `busy_o` = 0, `sleep_o` = 0 and `sdata_oe_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_start_n | input | 1 | Convert request, falling edge starts a conversion |
| sample_word | input | DATA_W | Parallel test value captured at conversion start |
| sclk | input | 1 | External serial clock, asynchronous |
| busy_o | output | 1 | High while a conversion runs |
| sleep_o | output | 1 | Power-down state |
| sdata_o | output | 1 | Serial data bit |
| sdata_oe_o | output | 1 | Serial data driver enable (0 = high impedance) |

## Verification
Two functions can fall in the same clock cycle: the completion of a conversion, which loads a new frame, and the acceptance of a synchronised serial-clock falling edge. The bench provokes this by dropping `sclk` three cycles before the counted end of busy, so that the edge reaches the shifter at the very edge where busy clears. The edge must not consume bit 0. This is judged by reading the next 16 edges: an all-ones word shows the frame correctly aligned, and the driver releases only after the 16th read.

// File: rtl/cse_pkg.sv
package cse_pkg;
    // Serial shifter modes, shared by the shifter and the checker
    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,   // pin released
        SH_DRIVE = 2'd1,   // bit on pin, waiting for a falling serial edge
        SH_HOLD  = 2'd2    // edge seen, keeping the old bit for the hold time
    } sh_mode_e;
endpackage

// File: rtl/cse_edge_sync.sv
module cse_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic fall_o
);
    // STAGES synchroniser flops plus one history flop for edge detection
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], raw_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign fall_o = chain_q[CHAIN_W-1] & ~chain_q[CHAIN_W-2];
endmodule

// File: rtl/cse_conv_ctrl.sv
module cse_conv_ctrl #(
    parameter int DATA_W      = 12,
    parameter int CONV_CYCLES = 400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_n_i,
    input  logic [DATA_W-1:0] word_i,
    output logic              busy_o,
    output logic              sleep_o,
    output logic              done_o,
    output logic [DATA_W-1:0] held_o
);
    localparam int CNT_W = $clog2(CONV_CYCLES + 1);

    typedef struct packed {
        logic              busy;
        logic              sleep;
        logic              prev_n;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] held;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  start_fall, start_rise, done_c;

    always_comb begin
        st_d       = st_q;
        done_c     = 1'b0;
        start_fall = st_q.prev_n & ~start_n_i;
        start_rise = ~st_q.prev_n & start_n_i;
        st_d.prev_n = start_n_i;

        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy  = 1'b0;
                done_c     = 1'b1;
                st_d.sleep = ~start_n_i;   // level at completion picks sleep
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (start_fall) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CNT_W'(CONV_CYCLES - 1);
            st_d.held = word_i;
        end

        if (start_rise) st_d.sleep = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.prev_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o  = st_q.busy;
    assign sleep_o = st_q.sleep;
    assign done_o  = done_c;
    assign held_o  = st_q.held;
endmodule

// File: rtl/cse_frame_shift.sv
module cse_frame_shift
    import cse_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int LEAD_W      = 4,
    parameter int HOLD_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic              fall_i,
    input  logic              busy_i,
    output logic              bit_o,
    output logic              oe_o,
    output sh_mode_e          mode_o
);
    localparam int FRAME_W = DATA_W + LEAD_W;
    localparam int HOLD_W  = $clog2(HOLD_CYCLES + 1);
    localparam int IDX_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        sh_mode_e           mode;
        logic [FRAME_W-1:0] frame;
        logic [IDX_W-1:0]   sent;
        logic [HOLD_W-1:0]  hold;
    } shift_t;

    shift_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i) begin
            sh_d.mode  = SH_DRIVE;
            sh_d.frame = {{LEAD_W{1'b0}}, word_i};
            sh_d.sent  = '0;
            sh_d.hold  = '0;
        end else begin
            unique case (sh_q.mode)
                SH_DRIVE: begin
                    if (fall_i && !busy_i) begin
                        sh_d.mode = SH_HOLD;
                        sh_d.hold = HOLD_W'(HOLD_CYCLES - 1);
                    end
                end
                SH_HOLD: begin
                    if (sh_q.hold == '0) begin
                        sh_d.sent = sh_q.sent + 1'b1;
                        if (sh_q.sent == IDX_W'(FRAME_W - 1)) begin
                            sh_d.mode = SH_IDLE;
                        end else begin
                            sh_d.mode  = SH_DRIVE;
                            sh_d.frame = sh_q.frame << 1;
                        end
                    end else begin
                        sh_d.hold = sh_q.hold - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q      <= '0;
            sh_q.mode <= SH_IDLE;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign bit_o  = sh_q.frame[FRAME_W-1];
    assign oe_o   = (sh_q.mode != SH_IDLE);
    assign mode_o = sh_q.mode;
endmodule

// File: rtl/conv_serial_emu.sv
module conv_serial_emu
    import cse_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int LEAD_W      = 4,
    parameter int CONV_CYCLES = 400,
    parameter int HOLD_CYCLES = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_start_n,
    input  logic [DATA_W-1:0] sample_word,
    input  logic              sclk,
    output logic              busy_o,
    output logic              sleep_o,
    output logic              sdata_o,
    output logic              sdata_oe_o
);
    logic              sclk_fall;
    logic              conv_done;
    logic [DATA_W-1:0] held_word;
    sh_mode_e          sh_mode;

    cse_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (sclk),
        .fall_o (sclk_fall)
    );

    cse_conv_ctrl #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_n_i (conv_start_n),
        .word_i    (sample_word),
        .busy_o    (busy_o),
        .sleep_o   (sleep_o),
        .done_o    (conv_done),
        .held_o    (held_word)
    );

    cse_frame_shift #(.DATA_W(DATA_W), .LEAD_W(LEAD_W), .HOLD_CYCLES(HOLD_CYCLES)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (conv_done),
        .word_i (held_word),
        .fall_i (sclk_fall),
        .busy_i (busy_o),
        .bit_o  (sdata_o),
        .oe_o   (sdata_oe_o),
        .mode_o (sh_mode)
    );
endmodule

// File: rtl/cse_checker.sv
module cse_checker
    import cse_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input logic     conv_start_n,
    input logic     busy,
    input logic     sleep,
    input logic     sclk_fall,
    input sh_mode_e mode,
    input logic     sdata_oe
);
    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(conv_start_n));

    // R4
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep) |-> $fell(busy));

    // R4
    sleep_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep) |-> $past(conv_start_n));

    // R8
    busy_edge_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sclk_fall && mode == SH_DRIVE) |=> (mode == SH_DRIVE));

    // R7
    release_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdata_oe) |-> ($past(mode) == SH_HOLD));

    // R5
    drive_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdata_oe) |-> $fell(busy));
endmodule

bind conv_serial_emu cse_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .conv_start_n (conv_start_n),
    .busy         (busy_o),
    .sleep        (sleep_o),
    .sclk_fall    (sclk_fall),
    .mode         (sh_mode),
    .sdata_oe     (sdata_oe_o)
);

// File: tb/conv_serial_emu_bench.sv
module conv_serial_emu_bench;
    localparam int DW = 12;
    localparam int C  = 40;
    localparam int H  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_start_n = 1'b1;
    logic [DW-1:0] sample_word = '0;
    logic sclk = 1'b0;
    logic busy_o, sleep_o, sdata_o, sdata_oe_o;

    int errors = 0;
    int checks = 0;
    logic mon_on = 1'b0;
    logic exp_q[$];
    logic [15:0] cur_frame = '0;

    always #10 clk = ~clk;   // 50 MHz

    conv_serial_emu #(.DATA_W(DW), .LEAD_W(4), .CONV_CYCLES(C),
                      .HOLD_CYCLES(H), .SYNC_STAGES(2)) u_conv_serial_emu (
        .clk          (clk),
        .rst_n        (rst_n),
        .conv_start_n (conv_start_n),
        .sample_word  (sample_word),
        .sclk         (sclk),
        .busy_o       (busy_o),
        .sleep_o      (sleep_o),
        .sdata_o      (sdata_o),
        .sdata_oe_o   (sdata_oe_o)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Monitor: each bench-driven falling serial edge reads the pin just before it
    always @(negedge sclk) begin
        if (mon_on) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected read", 0, 1);
            end else begin
                automatic logic e = exp_q.pop_front();
                check(sdata_oe_o === 1'b1 && sdata_o === e, "R5 frame bit",
                      int'({sdata_oe_o, sdata_o}), int'({1'b1, e}));
            end
        end
    end

    // Driver: one conversion, with optional mid-busy stimulus
    task automatic convert(input logic [DW-1:0] word, input int retrig_at,
                           input logic keep_low, input logic edge_test);
        int n;
        cur_frame = {4'b0000, word};
        for (int i = 15; i >= 0; i--) exp_q.push_back(cur_frame[i]);
        @(negedge clk);
        sample_word  = word;
        conv_start_n = 1'b0;
        @(negedge clk);
        if (!keep_low) conv_start_n = 1'b1;
        sample_word = ~word;   // R1: must not reach the frame
        n = 0;
        while (busy_o === 1'b1 && n < C + 10) begin
            n++;
            if (retrig_at > 0 && n == retrig_at) begin
                conv_start_n = 1'b0;   // R3: falling edge during busy
                sample_word  = word ^ 12'h5A5;
            end
            if (retrig_at > 0 && n == retrig_at + 1) conv_start_n = 1'b1;
            if (edge_test) begin
                if (n == 5)     sclk = 1'b1;   // R8: edges during busy
                if (n == 8)     sclk = 1'b0;
                if (n == C - 6) sclk = 1'b1;
                if (n == C - 2) sclk = 1'b0;   // R8: lands on completion edge
            end
            @(negedge clk);
        end
        check(n == C, "R2 busy length", n, C);
        check(sdata_oe_o === 1'b1 && sdata_o === 1'b0, "R5 first bit at done",
              int'({sdata_oe_o, sdata_o}), 2);
        check(sleep_o === keep_low, "R4 sleep at done", int'(sleep_o), int'(keep_low));
        if (keep_low) begin
            conv_start_n = 1'b1;
            @(negedge clk);
            check(sleep_o === 1'b0, "R4 wake on rise", int'(sleep_o), 0);
        end
    endtask

    // Reads 16 bits, checking hold timing around every edge
    task automatic read_frame();
        mon_on = 1'b1;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk) sclk = 1'b1;
            repeat (2) @(negedge clk);
            sclk = 1'b0;
            repeat (H + 2) @(negedge clk);
            check(sdata_oe_o === 1'b1 && sdata_o === cur_frame[15 - i], "R6 hold old bit",
                  int'({sdata_oe_o, sdata_o}), int'({1'b1, cur_frame[15 - i]}));
            @(negedge clk);
            if (i < 15)
                check(sdata_oe_o === 1'b1 && sdata_o === cur_frame[14 - i], "R6 next bit",
                      int'({sdata_oe_o, sdata_o}), int'({1'b1, cur_frame[14 - i]}));
            else
                check(sdata_oe_o === 1'b0, "R7 release", int'(sdata_oe_o), 0);
            repeat (2) @(negedge clk);
        end
        mon_on = 1'b0;
        check(exp_q.size() == 0, "R5 all bits read", exp_q.size(), 0);
        // R7: extra edges after the frame leave the pin released
        @(negedge clk) sclk = 1'b1;
        repeat (3) @(negedge clk);
        sclk = 1'b0;
        repeat (H + 6) @(negedge clk);
        check(sdata_oe_o === 1'b0, "R7 stays released", int'(sdata_oe_o), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9
        check(busy_o === 1'b0 && sleep_o === 1'b0 && sdata_oe_o === 1'b0, "R9 reset state",
              int'({busy_o, sleep_o, sdata_oe_o}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(busy_o === 1'b0 && sdata_oe_o === 1'b0, "R9 after release",
              int'({busy_o, sdata_oe_o}), 0);

        // R1, R2, R5, R6, R7 with several words
        convert(12'hA5C, 0, 1'b0, 1'b0); read_frame();
        convert(12'hFFF, 0, 1'b0, 1'b0); read_frame();
        convert(12'h000, 0, 1'b0, 1'b0); read_frame();
        convert(12'h801, 0, 1'b0, 1'b0); read_frame();

        // R3: second falling request in the middle of busy
        convert(12'h123, 10, 1'b0, 1'b0); read_frame();

        // R8: serial edges during busy and on the completion edge
        convert(12'hFFF, 0, 1'b0, 1'b1); read_frame();

        // R4: request held low through completion, then woken
        convert(12'h3C6, 0, 1'b1, 1'b0); read_frame();
        check(sleep_o === 1'b0, "R4 awake after frame", int'(sleep_o), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule